// File: doc/BRIEF.md
# Dual-Slot Instruction Packet Dispatcher

This block sits between instruction fetch and the execute units of a core that packs either one long operation or two short operations into each 32-bit word. It takes one packet at a time over a valid/ready handshake. The two top bits of the packet select the format. The block then hands the contained operations, one per cycle, to an execute port that also uses a valid/ready handshake. Each operation carries a role tag.

After each issued slot, the execute side returns a status strobe with three flags: the program counter was redirected, an exception was raised, and the condition tested true. The dispatcher uses these flags to decide whether a partner slot still runs. When the packet is finished it emits a one-cycle completion strobe, plus one-cycle event pulses that profiling counters can accumulate.

A single sideband bit per short slot, sampled together with the packet, marks that slot as a conditional test.

Top module: `dsp_dispatch`

## Requirements
- R1: Packet bits 31:30 equal to 2'b11 issue exactly one slot with tag 0 and payload bits 29:0.
- R2: Bits 31:30 equal to 2'b10 issue the right slot first (payload bits 14:0, tag 2), then the left slot (payload bits 29:15, tag 1). Short payloads are zero-extended to 30 bits.
- R3: Bits 31:30 equal to 2'b01 issue the left slot first (tag 1), then the right slot (tag 2).
- R4: In the 2'b01 and 2'b10 formats, the second slot is dropped if the first result reports a PC redirect or an exception. Event bit 6 pulses when the drop is caused by a redirect without an exception.
- R5: In format 2'b00 with cond_left_i set, the left slot issues first with tag 5. The right slot issues with tag 6 only when the returned condition flag is 1. Event bit 4 pulses on a true condition and event bit 5 pulses on a false one. This rule also applies when both sideband bits are set.
- R6: In format 2'b00 with only cond_right_i set, the right slot issues first with tag 7. The left slot issues with tag 8 only when the condition flag is 1. The event bits are the same as in R5.
- R7: In format 2'b00 with neither sideband bit set, the left slot issues first with tag 3. The right slot follows with tag 4 unless the left result reports an exception. A PC redirect has no effect here.
- R8: pkt_ready_o is low from the cycle after a packet is accepted until pkt_done_o pulses, so a packet offered meanwhile is not taken. While slot_ready_i is low, the issued slot holds its valid, tag and payload.
- R9: pkt_done_o pulses for one cycle after the final result or the drop decision. Exactly one format event pulses per packet: bit 0 for long, bit 1 for 2'b01, bit 2 for 2'b10, bit 3 for 2'b00.
- R10: After reset, pkt_ready_o is high, and slot_valid_o, pkt_done_o and evt_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Packet offered |
| pkt_ready_o | output | 1 | Dispatcher idle and able to take a packet |
| pkt_word_i | input | 32 | Packet word |
| cond_left_i | input | 1 | Left short slot is a conditional test |
| cond_right_i | input | 1 | Right short slot is a conditional test |
| slot_valid_o | output | 1 | Slot offered to the execute port |
| slot_ready_i | input | 1 | Execute port takes the slot |
| slot_tag_o | output | 4 | Role tag of the offered slot |
| slot_payload_o | output | 30 | Slot payload, short slots zero-extended |
| res_valid_i | input | 1 | Result status for the last taken slot |
| res_pc_chg_i | input | 1 | Slot redirected the PC |
| res_exc_i | input | 1 | Slot raised an exception |
| res_cond_i | input | 1 | Condition tested true |
| pkt_done_o | output | 1 | Packet completed (one-cycle pulse) |
| evt_o | output | 7 | Profiling event pulses |

## Verification
The hardest cases to reach are the partner-suppression decisions. In each one, a flag returned for the first slot must cancel or allow a second slot that the block has not issued yet. The cancelled case is only visible as a slot that never appears and a pulse on a specific event bit. The vector table drives every combination that matters: a redirect alone, an exception alone, both together, and true and false conditions with each slot acting as the test. For each packet the bench counts the issued slots and accumulates the events until the completion strobe.

A directed case holds slot_ready_i low while a second packet is offered. It checks that the slot stays frozen and that the second packet is refused.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int TAG_W = 4;
  localparam int EVT_N = 7;

  localparam int EV_LONG   = 0;
  localparam int EV_SEQ_LR = 1;
  localparam int EV_SEQ_RL = 2;
  localparam int EV_PAR    = 3;
  localparam int EV_CTRUE  = 4;
  localparam int EV_CFALSE = 5;
  localparam int EV_SKIP   = 6;

  typedef enum logic [1:0] {
    FMT_PAR    = 2'b00,
    FMT_SEQ_LR = 2'b01,
    FMT_SEQ_RL = 2'b10,
    FMT_LONG   = 2'b11
  } fmt_t;

  typedef enum logic [TAG_W-1:0] {
    TAG_LONG       = 4'd0,
    TAG_LEFT_SEQ   = 4'd1,
    TAG_RIGHT_SEQ  = 4'd2,
    TAG_LEFT_PAR   = 4'd3,
    TAG_RIGHT_PAR  = 4'd4,
    TAG_LEFT_TEST  = 4'd5,
    TAG_RIGHT_EXEC = 4'd6,
    TAG_RIGHT_TEST = 4'd7,
    TAG_LEFT_EXEC  = 4'd8
  } tag_t;

  typedef enum logic [1:0] {
    K_LONG,
    K_SEQ,
    K_PAR_PLAIN,
    K_PAR_COND
  } kind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE1,
    ST_WAIT1,
    ST_ISSUE2,
    ST_WAIT2
  } state_t;
endpackage

// File: rtl/dsp_decode.sv
module dsp_decode
  import dsp_pkg::*;
#(
  parameter int SHORT_W = 15,
  localparam int LONG_W = 2 * SHORT_W,
  localparam int WORD_W = LONG_W + 2
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              cond_left_i,
  input  logic              cond_right_i,
  output kind_t             kind_o,
  output tag_t              first_tag_o,
  output logic [LONG_W-1:0] first_pay_o,
  output tag_t              second_tag_o,
  output logic [LONG_W-1:0] second_pay_o
);
  localparam logic [SHORT_W-1:0] ZPAD = '0;

  fmt_t              fmt;
  logic [LONG_W-1:0] left_ext, right_ext;

  assign fmt       = fmt_t'(word_i[WORD_W-1 -: 2]);
  assign left_ext  = {ZPAD, word_i[LONG_W-1:SHORT_W]};
  assign right_ext = {ZPAD, word_i[SHORT_W-1:0]};

  always_comb begin
    kind_o       = K_PAR_PLAIN;
    first_tag_o  = TAG_LEFT_PAR;
    first_pay_o  = left_ext;
    second_tag_o = TAG_RIGHT_PAR;
    second_pay_o = right_ext;
    unique case (fmt)
      FMT_LONG: begin
        kind_o       = K_LONG;
        first_tag_o  = TAG_LONG;
        first_pay_o  = word_i[LONG_W-1:0];
        second_tag_o = TAG_LONG;
        second_pay_o = '0;
      end
      FMT_SEQ_RL: begin
        kind_o       = K_SEQ;
        first_tag_o  = TAG_RIGHT_SEQ;
        first_pay_o  = right_ext;
        second_tag_o = TAG_LEFT_SEQ;
        second_pay_o = left_ext;
      end
      FMT_SEQ_LR: begin
        kind_o       = K_SEQ;
        first_tag_o  = TAG_LEFT_SEQ;
        second_tag_o = TAG_RIGHT_SEQ;
      end
      FMT_PAR: begin
        // left test takes precedence when both slots claim to be tests
        if (cond_left_i) begin
          kind_o       = K_PAR_COND;
          first_tag_o  = TAG_LEFT_TEST;
          second_tag_o = TAG_RIGHT_EXEC;
        end else if (cond_right_i) begin
          kind_o       = K_PAR_COND;
          first_tag_o  = TAG_RIGHT_TEST;
          first_pay_o  = right_ext;
          second_tag_o = TAG_LEFT_EXEC;
          second_pay_o = left_ext;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dsp_issue_fsm.sv
module dsp_issue_fsm
  import dsp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_valid_i,
  input  logic [WORD_W-1:0] pkt_word_i,
  input  logic              cond_left_i,
  input  logic              cond_right_i,
  output logic              pkt_ready_o,
  output logic [WORD_W-1:0] word_o,
  output logic              cond_left_o,
  output logic              cond_right_o,
  input  kind_t             kind_i,
  output logic              slot_valid_o,
  output logic              second_sel_o,
  input  logic              slot_ready_i,
  input  logic              res_valid_i,
  input  logic              res_pc_chg_i,
  input  logic              res_exc_i,
  input  logic              res_cond_i,
  output logic              pkt_done_o,
  output logic [EVT_N-1:0]  evt_o
);
  state_t            state_q, state_d;
  logic [WORD_W-1:0] word_q;
  logic              cl_q, cr_q;
  logic              done_d;
  logic [EVT_N-1:0]  evt_d;
  logic              accept, go_second;

  assign accept       = pkt_valid_i && pkt_ready_o;
  assign pkt_ready_o  = (state_q == ST_IDLE);
  assign slot_valid_o = (state_q == ST_ISSUE1) || (state_q == ST_ISSUE2);
  assign second_sel_o = (state_q == ST_ISSUE2);
  assign word_o       = word_q;
  assign cond_left_o  = cl_q;
  assign cond_right_o = cr_q;

  always_comb begin
    unique case (kind_i)
      K_SEQ:       go_second = !res_pc_chg_i && !res_exc_i;
      K_PAR_COND:  go_second = res_cond_i;
      K_PAR_PLAIN: go_second = !res_exc_i;
      default:     go_second = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    evt_d   = '0;
    unique case (state_q)
      ST_IDLE: if (pkt_valid_i) begin
        state_d = ST_ISSUE1;
        unique case (fmt_t'(pkt_word_i[WORD_W-1 -: 2]))
          FMT_LONG:   evt_d[EV_LONG]   = 1'b1;
          FMT_SEQ_LR: evt_d[EV_SEQ_LR] = 1'b1;
          FMT_SEQ_RL: evt_d[EV_SEQ_RL] = 1'b1;
          default:    evt_d[EV_PAR]    = 1'b1;
        endcase
      end
      ST_ISSUE1: if (slot_ready_i) state_d = ST_WAIT1;
      ST_WAIT1: if (res_valid_i) begin
        if (kind_i == K_PAR_COND) begin
          evt_d[EV_CTRUE]  = res_cond_i;
          evt_d[EV_CFALSE] = !res_cond_i;
        end
        if (kind_i == K_SEQ) evt_d[EV_SKIP] = res_pc_chg_i && !res_exc_i;
        if (go_second) state_d = ST_ISSUE2;
        else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      ST_ISSUE2: if (slot_ready_i) state_d = ST_WAIT2;
      ST_WAIT2: if (res_valid_i) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      word_q     <= '0;
      cl_q       <= 1'b0;
      cr_q       <= 1'b0;
      pkt_done_o <= 1'b0;
      evt_o      <= '0;
    end else begin
      state_q    <= state_d;
      pkt_done_o <= done_d;
      evt_o      <= evt_d;
      if (accept) begin
        word_q <= pkt_word_i;
        cl_q   <= cond_left_i;
        cr_q   <= cond_right_i;
      end
    end
  end

  p_no_accept_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_ready_o) |=> !pkt_ready_o);

  p_done_to_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |-> pkt_ready_o && !slot_valid_o);

  p_cond_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_o[EV_CTRUE] && evt_o[EV_CFALSE]));

  p_skip_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o[EV_SKIP] |-> $past(res_valid_i && res_pc_chg_i && !res_exc_i) && pkt_done_o);

  p_seq_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ISSUE2 && $past(state_q) == ST_WAIT1 && kind_i == K_SEQ)
      |-> !$past(res_pc_chg_i) && !$past(res_exc_i));

  p_cond_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ISSUE2 && $past(state_q) == ST_WAIT1 && kind_i == K_PAR_COND)
      |-> $past(res_cond_i));

  p_fmt_evt_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(evt_o[EV_PAR:EV_LONG]) <= 1);
endmodule

// File: rtl/dsp_dispatch.sv
module dsp_dispatch
  import dsp_pkg::*;
#(
  parameter int SHORT_W = 15,
  localparam int LONG_W = 2 * SHORT_W,
  localparam int WORD_W = LONG_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_valid_i,
  output logic              pkt_ready_o,
  input  logic [WORD_W-1:0] pkt_word_i,
  input  logic              cond_left_i,
  input  logic              cond_right_i,
  output logic              slot_valid_o,
  input  logic              slot_ready_i,
  output logic [TAG_W-1:0]  slot_tag_o,
  output logic [LONG_W-1:0] slot_payload_o,
  input  logic              res_valid_i,
  input  logic              res_pc_chg_i,
  input  logic              res_exc_i,
  input  logic              res_cond_i,
  output logic              pkt_done_o,
  output logic [EVT_N-1:0]  evt_o
);
  logic [WORD_W-1:0] word_q;
  logic              cl_q, cr_q, second_sel;
  kind_t             kind;
  tag_t              t1, t2;
  logic [LONG_W-1:0] p1, p2;

  dsp_issue_fsm #(.WORD_W(WORD_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pkt_valid_i  (pkt_valid_i),
    .pkt_word_i   (pkt_word_i),
    .cond_left_i  (cond_left_i),
    .cond_right_i (cond_right_i),
    .pkt_ready_o  (pkt_ready_o),
    .word_o       (word_q),
    .cond_left_o  (cl_q),
    .cond_right_o (cr_q),
    .kind_i       (kind),
    .slot_valid_o (slot_valid_o),
    .second_sel_o (second_sel),
    .slot_ready_i (slot_ready_i),
    .res_valid_i  (res_valid_i),
    .res_pc_chg_i (res_pc_chg_i),
    .res_exc_i    (res_exc_i),
    .res_cond_i   (res_cond_i),
    .pkt_done_o   (pkt_done_o),
    .evt_o        (evt_o)
  );

  dsp_decode #(.SHORT_W(SHORT_W)) u_dec (
    .word_i       (word_q),
    .cond_left_i  (cl_q),
    .cond_right_i (cr_q),
    .kind_o       (kind),
    .first_tag_o  (t1),
    .first_pay_o  (p1),
    .second_tag_o (t2),
    .second_pay_o (p2)
  );

  assign slot_tag_o     = second_sel ? t2 : t1;
  assign slot_payload_o = second_sel ? p2 : p1;

  p_slot_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_valid_o && !slot_ready_i) |=>
      slot_valid_o && $stable(slot_tag_o) && $stable(slot_payload_o));

  p_long_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_valid_o && slot_tag_o == TAG_LONG) |-> !second_sel);
endmodule

// File: tb/tb_dsp_dispatch.sv
module tb_dsp_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] F0 = 3'b000, FPC = 3'b100, FEX = 3'b010, FCD = 3'b001;

  typedef struct packed {
    logic [31:0] word;
    logic        cl, cr;
    logic [2:0]  r1, r2;
    logic [1:0]  n;
    logic [3:0]  t1;
    logic [29:0] p1;
    logic [3:0]  t2;
    logic [29:0] p2;
    logic [6:0]  ev;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'hC91A0ABC, 1'b0, 1'b0, F0,  F0,  2'd1, 4'd0, 30'h091A0ABC, 4'd0, 30'h0,    7'h01},
    '{32'h7FFF8001, 1'b0, 1'b0, F0,  FEX, 2'd2, 4'd1, 30'h7FFF,     4'd2, 30'h0001, 7'h02},
    '{32'h891A0ABC, 1'b0, 1'b0, F0,  F0,  2'd2, 4'd2, 30'h0ABC,     4'd1, 30'h1234, 7'h04},
    '{32'h491A0ABC, 1'b0, 1'b0, FPC, F0,  2'd1, 4'd1, 30'h1234,     4'd0, 30'h0,    7'h42},
    '{32'h891A0ABC, 1'b0, 1'b0, FEX, F0,  2'd1, 4'd2, 30'h0ABC,     4'd0, 30'h0,    7'h04},
    '{32'h491A0ABC, 1'b0, 1'b0, FPC|FEX, F0, 2'd1, 4'd1, 30'h1234,  4'd0, 30'h0,    7'h02},
    '{32'h091A0ABC, 1'b1, 1'b0, FCD, F0,  2'd2, 4'd5, 30'h1234,     4'd6, 30'h0ABC, 7'h18},
    '{32'h091A0ABC, 1'b1, 1'b0, F0,  F0,  2'd1, 4'd5, 30'h1234,     4'd0, 30'h0,    7'h28},
    '{32'h091A0ABC, 1'b0, 1'b1, FCD, F0,  2'd2, 4'd7, 30'h0ABC,     4'd8, 30'h1234, 7'h18},
    '{32'h091A0ABC, 1'b0, 1'b1, FEX, F0,  2'd1, 4'd7, 30'h0ABC,     4'd0, 30'h0,    7'h28},
    '{32'h091A0ABC, 1'b1, 1'b1, FCD, F0,  2'd2, 4'd5, 30'h1234,     4'd6, 30'h0ABC, 7'h18},
    '{32'h091A0ABC, 1'b0, 1'b0, F0,  F0,  2'd2, 4'd3, 30'h1234,     4'd4, 30'h0ABC, 7'h08},
    '{32'h091A0ABC, 1'b0, 1'b0, FEX, F0,  2'd1, 4'd3, 30'h1234,     4'd0, 30'h0,    7'h08},
    '{32'h091A0ABC, 1'b0, 1'b0, FPC|FCD, F0, 2'd2, 4'd3, 30'h1234,  4'd4, 30'h0ABC, 7'h08},
    '{32'hC91A0ABC, 1'b0, 1'b0, FEX, F0,  2'd1, 4'd0, 30'h091A0ABC, 4'd0, 30'h0,    7'h01}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        pkt_valid_i = 1'b0, cond_left_i = 1'b0, cond_right_i = 1'b0;
  logic [31:0] pkt_word_i = '0;
  logic        slot_ready_i = 1'b1;
  logic        res_valid_i = 1'b0, res_pc_chg_i = 1'b0, res_exc_i = 1'b0, res_cond_i = 1'b0;
  logic        pkt_ready_o, slot_valid_o, pkt_done_o;
  logic [3:0]  slot_tag_o;
  logic [29:0] slot_payload_o;
  logic [6:0]  evt_o;

  int checks = 0, errors = 0;

  dsp_dispatch dut (
    .clk_i, .rst_ni, .pkt_valid_i, .pkt_ready_o, .pkt_word_i, .cond_left_i, .cond_right_i,
    .slot_valid_o, .slot_ready_i, .slot_tag_o, .slot_payload_o,
    .res_valid_i, .res_pc_chg_i, .res_exc_i, .res_cond_i, .pkt_done_o, .evt_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int          nslot = 0;
    bit          give_res = 0, done = 0;
    logic [6:0]  ev_acc = '0;
    logic [3:0]  tg [2];
    logic [29:0] pl [2];
    string       rq;
    tg[0] = '0; tg[1] = '0; pl[0] = '0; pl[1] = '0;
    rq = $sformatf("R1-class vec%0d", idx);
    case (v.word[31:30])
      2'b11: rq = $sformatf("R1 vec%0d", idx);
      2'b10: rq = $sformatf("R2/R4 vec%0d", idx);
      2'b01: rq = $sformatf("R3/R4 vec%0d", idx);
      default: rq = v.cl ? $sformatf("R5 vec%0d", idx)
                  : v.cr ? $sformatf("R6 vec%0d", idx) : $sformatf("R7 vec%0d", idx);
    endcase
    @(negedge clk_i);
    pkt_valid_i = 1'b1; pkt_word_i = v.word; cond_left_i = v.cl; cond_right_i = v.cr;
    @(posedge clk_i);
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk_i);
      pkt_valid_i = 1'b0; res_valid_i = 1'b0;
      ev_acc |= evt_o;
      if (pkt_done_o) begin done = 1; break; end
      if (give_res) begin
        res_valid_i = 1'b1;
        {res_pc_chg_i, res_exc_i, res_cond_i} = (nslot == 1) ? v.r1 : v.r2;
        give_res = 0;
      end else if (slot_valid_o) begin
        if (nslot < 2) begin tg[nslot] = slot_tag_o; pl[nslot] = slot_payload_o; end
        nslot++;
        give_res = 1;
      end
    end
    check(done == 1, {rq, " done"}, 32'(done), 32'd1);
    check(nslot == int'(v.n), {rq, " slot count"}, 32'(nslot), 32'(v.n));
    check(tg[0] == v.t1 && pl[0] == v.p1, {rq, " first slot"}, {tg[0], pl[0][27:0]}, {v.t1, v.p1[27:0]});
    if (v.n == 2)
      check(tg[1] == v.t2 && pl[1] == v.p2, {rq, " second slot"}, {tg[1], pl[1][27:0]}, {v.t2, v.p2[27:0]});
    check(ev_acc == v.ev, {rq, " R9 events"}, 32'(ev_acc), 32'(v.ev));
    @(negedge clk_i);
    check(!pkt_done_o && pkt_ready_o && evt_o == 0, {rq, " R9 done single pulse"},
          {pkt_done_o, pkt_ready_o, evt_o}, 32'h0080);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check(pkt_ready_o && !slot_valid_o && !pkt_done_o && evt_o == 0, "R10 reset state",
          {pkt_ready_o, slot_valid_o, pkt_done_o, evt_o}, 32'h200);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(pkt_ready_o && !slot_valid_o, "R10 after release", {pkt_ready_o, slot_valid_o}, 32'h2);

    foreach (VECS[i]) run_vec(VECS[i], i);

    // R8: stall on the execute port while another packet is offered
    @(negedge clk_i);
    slot_ready_i = 1'b0;
    pkt_valid_i = 1'b1; pkt_word_i = 32'h491A0ABC; cond_left_i = 0; cond_right_i = 0;
    @(posedge clk_i);
    @(negedge clk_i);
    pkt_word_i = 32'hC0000000;
    check(slot_valid_o && slot_tag_o == 4'd1 && slot_payload_o == 30'h1234, "R8 first slot offered",
          {slot_tag_o, slot_payload_o[27:0]}, {4'd1, 28'h1234});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      check(slot_valid_o && slot_tag_o == 4'd1 && slot_payload_o == 30'h1234, "R8 slot held",
            {slot_valid_o, slot_tag_o, slot_payload_o[26:0]}, {1'b1, 4'd1, 27'h1234});
      check(!pkt_ready_o && evt_o == 0, "R8 busy refuses packet", {pkt_ready_o, evt_o}, 32'h0);
    end
    slot_ready_i = 1'b1;
    @(negedge clk_i);
    res_valid_i = 1'b1; {res_pc_chg_i, res_exc_i, res_cond_i} = F0;
    @(negedge clk_i);
    res_valid_i = 1'b0;
    check(slot_valid_o && slot_tag_o == 4'd2 && slot_payload_o == 30'h0ABC && !pkt_ready_o,
          "R8 R3 second slot after stall", {slot_tag_o, slot_payload_o[27:0]}, {4'd2, 28'h0ABC});
    @(negedge clk_i);
    res_valid_i = 1'b1;
    @(negedge clk_i);
    res_valid_i = 1'b0; pkt_valid_i = 1'b0;
    check(pkt_done_o && pkt_ready_o && evt_o == 0, "R9 done after stalled packet",
          {pkt_done_o, pkt_ready_o, evt_o}, 32'h180);
    @(negedge clk_i);
    check(!pkt_done_o && !slot_valid_o, "R8 held packet not taken after done",
          {pkt_done_o, slot_valid_o}, 32'h0);

    finish_run();
  end
endmodule